// File: doc/BRIEF.md
# T1-over-E1 Backplane Payload Extractor

The block takes a high-speed backplane stream in which each 256-bit, 32-slot frame carries one 193-bit T1 frame, and turns it back into a plain 193-bit T1 bit stream. The input clock runs at twice the bit rate: a new bit is presented on every second rising edge, and the block samples on every second falling edge. A frame-sync pulse marks the first bit of each 256-bit frame. Only the first bit of slot 0 (the framing bit) and the 24 payload octets are kept. The other seven bits of slot 0 are dropped, and so is every slot whose index is a multiple of four.

The kept bits, each tagged with a frame-start marker, cross into an independent free-running output clock domain through a dual-clock FIFO with Gray-coded pointers. On the output side one bit is emitted on each clock, and a one-cycle strobe flags each framing bit. Sticky flags report FIFO overflow, FIFO underflow and a sync pulse seen at the wrong position. Neither edge has back-pressure. The input cannot stall, so a write into a full FIFO is lost. The output is paced by its own clock, so a missing bit shows as a cycle with the valid output low.

Top module: `t1e1_unpacker`

## Requirements
- R1: While rst_n is low, and in the first output clock after it, out_valid, out_sof, out_bit and fifo_unf are 0. fifo_ovf and misalign are cleared in the input domain.
- R2: One bit is sampled on every second falling edge of in_clk. A rising in_sync realigns that choice so that the bit presented with the pulse is sampled as bit 0. The value present at the skipped falling edge has no effect on the output.
- R3: Bit 0 of the 256-bit frame (the first bit of slot 0, its MSB) is the framing bit and is kept. Bits 1 to 7 of slot 0 never reach the output.
- R4: Slots 4, 8, ..., 28 are dropped entirely. Slot k (k = 1..31, not a multiple of 4) becomes T1 slot k - 1 - floor(k/4). Bits keep their order, MSB first.
- R5: While running, out_valid is high for one bit per out_clk cycle. out_sof is high exactly on the cycles that carry a framing bit, and all kept bits come out in order.
- R6: After reset, out_valid stays low until at least 193 kept bits have been buffered.
- R7: After alignment, a rising in_sync at any position other than bit 0 sets the sticky misalign flag. The bit presented with that pulse is treated as bit 0 of a new frame, even if it falls in a padding slot.
- R8: Before the first rising in_sync after reset, no bit is buffered and out_valid stays low.
- R9: A kept bit that arrives while the FIFO is full is dropped, and the sticky fifo_ovf flag is set.
- R10: When the FIFO is empty on a running output cycle, out_valid is low for that cycle and the sticky fifo_unf flag is set.
- R11: Asserting rst_n low clears fifo_ovf, fifo_unf and misalign, and returns the output to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_clk | input | 1 | Backplane clock at twice the bit rate; sampling on its falling edge |
| out_clk | input | 1 | Free-running T1 output clock |
| rst_n | input | 1 | Active-low reset, synchronous in each clock domain |
| in_data | input | 1 | Serial backplane data |
| in_sync | input | 1 | Frame-sync pulse, high with bit 0 of the frame |
| out_bit | output | 1 | Recovered T1 bit |
| out_valid | output | 1 | out_bit carries a recovered bit this cycle |
| out_sof | output | 1 | Current bit is the framing bit of a 193-bit frame |
| fifo_ovf | output | 1 | Sticky: a kept bit was lost on a full FIFO (input domain) |
| fifo_unf | output | 1 | Sticky: the FIFO ran dry while running (output domain) |
| misalign | output | 1 | Sticky: a sync pulse arrived away from bit 0 (input domain) |

## Verification
Realignment and padding removal act on the same sample. A sync pulse that lands in a padding slot must turn a bit that the counter would drop into a kept framing bit. The bench provokes this with a truncated frame whose next sync rises at bit 33, inside padding slot 4. It then checks that this bit comes out with out_sof high, that the misalign flag is set, and that the rest of the stream still matches the model bit for bit.

// File: rtl/t1e1_pkg.sv
package t1e1_pkg;
  // one buffered bit plus its frame-start tag
  typedef struct packed {
    logic sof;
    logic dat;
  } fifo_word_t;
endpackage

// File: rtl/t1e1_in_align.sv
// Input-domain sampler: half-rate phase, frame counter, padding removal.
// All state moves on the falling edge of clk.
module t1e1_in_align #(
  parameter int IN_BITS   = 256,
  parameter int SLOT_BITS = 8,
  parameter int GROUP     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_data,
  input  logic in_sync,
  output logic wr_en,
  output t1e1_pkg::fifo_word_t wr_word,
  output logic misalign
);
  localparam int CW = $clog2(IN_BITS);
  localparam int SW = $clog2(SLOT_BITS);
  localparam int GW = $clog2(GROUP);

  logic          phase_q, sync_d, aligned_q, misalign_q;
  logic [CW-1:0] cnt_q, pos;
  logic          rise, take, keep;

  always_comb begin
    rise = in_sync & ~sync_d;
    take = phase_q | rise;
    pos  = rise ? '0 : cnt_q;
    // framing bit, or any slot not the last of its group of four
    keep = (pos == '0) | (pos[SW +: GW] != '0);
    wr_en        = take & (aligned_q | rise) & keep;
    wr_word.sof  = (pos == '0);
    wr_word.dat  = in_data;
  end

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      phase_q    <= 1'b0;
      sync_d     <= 1'b0;
      cnt_q      <= '0;
      aligned_q  <= 1'b0;
      misalign_q <= 1'b0;
    end else begin
      sync_d  <= in_sync;
      phase_q <= ~take;
      if (take)
        cnt_q <= (pos == CW'(IN_BITS - 1)) ? '0 : pos + 1'b1;
      if (rise) begin
        aligned_q <= 1'b1;
        if (aligned_q && cnt_q != '0)
          misalign_q <= 1'b1;
      end
    end
  end

  assign misalign = misalign_q;
endmodule

// File: rtl/t1e1_ptr_sync.sv
// Two-flop synchronizer for a Gray pointer; NEG picks the capture edge.
module t1e1_ptr_sync #(
  parameter int W   = 10,
  parameter bit NEG = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  generate
    if (NEG) begin : g_neg
      always_ff @(negedge clk) begin
        if (!rst_n) begin
          s1 <= '0;
          s2 <= '0;
        end else begin
          s1 <= d;
          s2 <= s1;
        end
      end
    end else begin : g_pos
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          s1 <= '0;
          s2 <= '0;
        end else begin
          s1 <= d;
          s2 <= s1;
        end
      end
    end
  endgenerate

  assign q = s2;
endmodule

// File: rtl/t1e1_cdc_fifo.sv
// Dual-clock FIFO: writes on the falling edge of wclk, reads on the rising
// edge of rclk, Gray pointers crossing through two-flop synchronizers.
module t1e1_cdc_fifo #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                 wclk,
  input  logic                 rclk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  t1e1_pkg::fifo_word_t wr_word,
  output logic                 ovf,
  input  logic                 rd_en,
  output t1e1_pkg::fifo_word_t rd_word,
  output logic                 rd_empty,
  output logic [PW-1:0]        rd_fill
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  t1e1_pkg::fifo_word_t mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rgray_w;
  logic [PW-1:0] rbin, rgray, wgray_r, wbin_r;
  logic          full, ovf_q;

  // write side
  assign full = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

  always_ff @(negedge wclk) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovf_q <= 1'b0;
    end else if (wr_en) begin
      if (full) begin
        ovf_q <= 1'b1;
      end else begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
    end
  end

  always_ff @(negedge wclk) begin
    if (rst_n && wr_en && !full)
      mem[wbin[AW-1:0]] <= wr_word;
  end

  // read side
  assign wbin_r   = from_gray(wgray_r);
  assign rd_empty = (rgray == wgray_r);
  assign rd_fill  = wbin_r - rbin;
  assign rd_word  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_en && !rd_empty) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end
  end

  t1e1_ptr_sync #(.W(PW), .NEG(1'b0)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r)
  );
  t1e1_ptr_sync #(.W(PW), .NEG(1'b1)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w)
  );

  assign ovf = ovf_q;
endmodule

// File: rtl/t1e1_out_seq.sv
// Output-domain sequencer: waits for one frame of fill, then one bit a cycle.
module t1e1_out_seq #(
  parameter int T1_BITS = 193,
  parameter int PW      = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_empty,
  input  logic [PW-1:0]        rd_fill,
  input  t1e1_pkg::fifo_word_t rd_word,
  output logic                 rd_en,
  output logic                 out_bit,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic                 unf
);
  logic running;

  assign rd_en = running & ~rd_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      unf       <= 1'b0;
    end else if (!running) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      if (rd_fill >= PW'(T1_BITS))
        running <= 1'b1;
    end else if (rd_empty) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      unf       <= 1'b1;
    end else begin
      out_valid <= 1'b1;
      out_bit   <= rd_word.dat;
      out_sof   <= rd_word.sof;
    end
  end
endmodule

// File: rtl/t1e1_unpacker.sv
module t1e1_unpacker #(
  parameter int IN_BITS    = 256,
  parameter int T1_BITS    = 193,
  parameter int SLOT_BITS  = 8,
  parameter int GROUP      = 4,
  parameter int FIFO_DEPTH = 512
) (
  input  logic in_clk,
  input  logic out_clk,
  input  logic rst_n,
  input  logic in_data,
  input  logic in_sync,
  output logic out_bit,
  output logic out_valid,
  output logic out_sof,
  output logic fifo_ovf,
  output logic fifo_unf,
  output logic misalign
);
  localparam int PW = $clog2(FIFO_DEPTH) + 1;

  t1e1_pkg::fifo_word_t wr_word, rd_word;
  logic                 wr_en, rd_en, rd_empty;
  logic [PW-1:0]        rd_fill;

  t1e1_in_align #(
    .IN_BITS(IN_BITS), .SLOT_BITS(SLOT_BITS), .GROUP(GROUP)
  ) u_align (
    .clk(in_clk), .rst_n(rst_n), .in_data(in_data), .in_sync(in_sync),
    .wr_en(wr_en), .wr_word(wr_word), .misalign(misalign)
  );

  t1e1_cdc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk(in_clk), .rclk(out_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_word(wr_word), .ovf(fifo_ovf),
    .rd_en(rd_en), .rd_word(rd_word), .rd_empty(rd_empty), .rd_fill(rd_fill)
  );

  t1e1_out_seq #(.T1_BITS(T1_BITS), .PW(PW)) u_out (
    .clk(out_clk), .rst_n(rst_n), .rd_empty(rd_empty), .rd_fill(rd_fill),
    .rd_word(rd_word), .rd_en(rd_en), .out_bit(out_bit),
    .out_valid(out_valid), .out_sof(out_sof), .unf(fifo_unf)
  );
endmodule

// File: rtl/t1e1_unpacker_chk.sv
module t1e1_unpacker_chk (
  input logic in_clk,
  input logic out_clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_sof,
  input logic fifo_ovf,
  input logic fifo_unf,
  input logic misalign
);
  // R1
  rst_out_idle_chk: assert property (@(posedge out_clk)
    !rst_n |=> (!out_valid && !out_sof && !fifo_unf));

  // R11
  rst_in_clear_chk: assert property (@(negedge in_clk)
    !rst_n |=> (!fifo_ovf && !misalign));

  // R5
  sof_with_valid_chk: assert property (@(posedge out_clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R7
  misalign_sticky_chk: assert property (@(negedge in_clk) disable iff (!rst_n)
    misalign |=> misalign);

  // R9
  ovf_sticky_chk: assert property (@(negedge in_clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

  // R10
  unf_sticky_chk: assert property (@(posedge out_clk) disable iff (!rst_n)
    fifo_unf |=> fifo_unf);

  // R10
  unf_gap_chk: assert property (@(posedge out_clk) disable iff (!rst_n)
    $rose(fifo_unf) |-> !out_valid);
endmodule

bind t1e1_unpacker t1e1_unpacker_chk u_chk (
  .in_clk(in_clk), .out_clk(out_clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_sof(out_sof),
  .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf), .misalign(misalign)
);

// File: tb/t1e1_unpacker_tb.sv
`timescale 1ns/1ps
module t1e1_unpacker_tb;
  logic in_clk = 1'b0, out_clk = 1'b0, rst_n = 1'b0;
  logic in_data = 1'b0, in_sync = 1'b0;
  logic out_bit, out_valid, out_sof, fifo_ovf, fifo_unf, misalign;
  real  out_half = 10.61;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 in_clk = ~in_clk;
  always #(out_half) out_clk = ~out_clk;

  t1e1_unpacker u_dut (
    .in_clk(in_clk), .out_clk(out_clk), .rst_n(rst_n),
    .in_data(in_data), .in_sync(in_sync),
    .out_bit(out_bit), .out_valid(out_valid), .out_sof(out_sof),
    .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf), .misalign(misalign)
  );

  // reference model state
  bit exp_bit[$];
  bit exp_sof[$];
  int bpos = 0, kept_sent = 0, first_kept = 0, sof_seen = 0;
  bit baligned = 0, seen_valid = 0, mon_en = 1;
  bit eb, es;

  function automatic bit keep_pos(int p);
    return (p == 0) || (((p / 8) % 4) != 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // output monitor, sampled away from the rising out_clk edge
  always @(negedge out_clk) begin
    if (rst_n && out_valid) begin
      if (!seen_valid) begin
        seen_valid = 1;
        first_kept = kept_sent;
      end
      if (mon_en && exp_bit.size() > 0) begin
        eb = exp_bit.pop_front();
        es = exp_sof.pop_front();
        check(out_bit == eb, es ? "R3 framing bit" : "R4 payload bit", out_bit, eb);
        check(out_sof == es, "R5 frame start", out_sof, es);
        if (es) sof_seen++;
      end
    end
  end

  // one bit: real value at the sampled falling edge, inverted at the skipped one
  task automatic send_bit(bit b, bit s);
    if (s) begin
      bpos = 0;
      baligned = 1;
    end
    if (baligned && keep_pos(bpos)) begin
      exp_bit.push_back(b);
      exp_sof.push_back(bpos == 0);
      kept_sent++;
    end
    bpos = (bpos + 1) % 256;
    @(posedge in_clk);
    in_data = b;
    in_sync = s;
    @(posedge in_clk);
    in_data = ~b;
    in_sync = 1'b0;
  endtask

  task automatic send_frames(int n, int len);
    for (int f = 0; f < n; f++)
      for (int p = 0; p < len; p++)
        send_bit(1'($urandom_range(0, 1)), p == 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_data = 1'b0;
    in_sync = 1'b0;
    #3000;
    exp_bit.delete();
    exp_sof.delete();
    bpos = 0; baligned = 0; kept_sent = 0;
    seen_valid = 0; sof_seen = 0; first_kept = 0;
    @(posedge in_clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #50;
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(out_sof == 0, "R1 out_sof", out_sof, 0);
    check({fifo_ovf, fifo_unf, misalign} == 3'b000, "R1 flags",
          {fifo_ovf, fifo_unf, misalign}, 0);
  endtask

  task automatic t_nosync();
    for (int i = 0; i < 300; i++) send_bit(1'(i % 3 == 0), 1'b0);
    #2000;
    check(seen_valid == 0, "R8 idle before sync", seen_valid, 0);
    check(out_valid == 0, "R8 out_valid", out_valid, 0);
  endtask

  task automatic t_stream();
    send_frames(6, 256);
    #8000;
    check(exp_bit.size() == 0, "R5 all kept bits delivered", exp_bit.size(), 0);
    check(sof_seen == 6, "R5 frame starts", sof_seen, 6);
    check(first_kept >= 193, "R6 wait for one frame", first_kept, 193);
    check(misalign == 0, "R7 no misalign on clean frames", misalign, 0);
    check(fifo_ovf == 0, "R9 no overflow at matched rates", fifo_ovf, 0);
    check(fifo_unf == 0, "R10 no underflow at matched rates", fifo_unf, 0);
    check(kept_sent == 6 * 193, "R2 R4 kept count", kept_sent, 6 * 193);
  endtask

  // a truncated frame: next sync rises at bit 33, inside padding slot 4
  task automatic t_misalign();
    do_reset();
    send_frames(2, 256);
    check(misalign == 0, "R7 before bad sync", misalign, 0);
    send_frames(1, 33);
    send_frames(3, 256);
    #8000;
    check(misalign == 1, "R7 misalign flag", misalign, 1);
    check(exp_bit.size() == 0, "R7 stream after realign", exp_bit.size(), 0);
    check(sof_seen == 6, "R7 frame starts incl. realigned", sof_seen, 6);
  endtask

  task automatic t_underflow();
    do_reset();
    out_half = 4.0;
    send_frames(3, 256);
    #1000;
    check(fifo_unf == 1, "R10 underflow flag", fifo_unf, 1);
    check(fifo_ovf == 0, "R9 no overflow on fast reader", fifo_ovf, 0);
    out_half = 10.61;
  endtask

  task automatic t_overflow();
    do_reset();
    mon_en = 0;
    out_half = 60.0;
    send_frames(5, 256);
    #500;
    check(fifo_ovf == 1, "R9 overflow flag", fifo_ovf, 1);
    out_half = 10.61;
    do_reset();
    #200;
    check(fifo_ovf == 0, "R11 overflow cleared", fifo_ovf, 0);
    check(fifo_unf == 0, "R11 underflow cleared", fifo_unf, 0);
    check(misalign == 0, "R11 misalign cleared", misalign, 0);
    check(out_valid == 0, "R11 output idle", out_valid, 0);
    mon_en = 1;
  endtask

  initial begin
    t_reset();
    t_nosync();
    t_stream();
    t_misalign();
    t_underflow();
    t_overflow();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule